// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

This block collects up to 48 single-wire event inputs and turns them into one level-sensitive, active-high interrupt request for a host. The sources are grouped into two banks of 24. Every bank holds a sticky status register that records events and a mask register that decides which recorded events may raise the request. A status bit is set by a rising edge on its event wire and stays set until the host clears it.

The host reaches the four registers through a plain register port. A write needs one clock. A read is combinational from the address. A service routine reads both status registers and both mask registers. It handles the unmasked pending events and then writes ones to the status bits it has dealt with. Event number n drives bank 0 bit n when n is below 24, and bank 1 bit n-24 otherwise. Some bit positions have no source wired to them and always read zero.

Top module: `irq_dual_bank`

## Requirements
- R1: Register offsets on `regAddr` are: bank 0 status at 0, bank 0 mask at 1, bank 1 status at 3, bank 1 mask at 4. Offsets 2, 5, 6 and 7 read as zero, and writes to them change no register.
- R2: Event input `evtIn[n]` feeds bank 0 status bit n for n from 0 to 23, and bank 1 status bit n-24 for n from 24 to 47.
- R3: A status bit is set at the first clock edge at which its event input is high after having been low at the previous edge. An input that is held high does not set the bit again after it has been cleared.
- R4: A status bit, once set, stays set whatever its mask bit is, until a write-one-to-clear removes it.
- R5: A write to a status offset clears every bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R6: When an event edge and a write of 1 to the same status bit fall in the same clock, the bit ends up set.
- R7: Both mask registers reset to 0x00FFFFFF. A mask bit of 1 blocks its source from the interrupt output and a mask bit of 0 lets it through. A write to a mask offset loads bits 23:0 of the data.
- R8: `irqOut` is high in the cycle after a register update exactly when, in either bank, some status bit is 1 and its mask bit is 0.
- R9: Bank 0 status bits 5, 17, 18 and 20 and bank 1 status bits 2 and 16 have no source and always read 0.
- R10: Bits 31:24 of every register read as 0, and the write data in those bits is ignored.
- R11: After reset both status registers read 0 and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 48 | Event wires, synchronous to clk; a rising edge records an event |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the register at regAddr (combinational) |
| irqOut | output | 1 | Level interrupt request, active high |

## Verification
The events are driven three ways. Single directed edges on chosen wires show the mapping to bank and bit. Wires held high across a clear show the difference between edge and level. A randomly toggled set of wires is mixed with random writes to every offset, and this exercises many bits of both banks against each other at once. Coincident edge-and-clear cycles separate a design in which set wins from one in which clear wins. Writes to the unused offsets and with the top byte set show whether a decode is too loose. Every cycle the bench compares the read data and the interrupt level with a bench-side model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_BANKS = 2;
  localparam int BANK_W = 24;
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int BANK_STRIDE = 3;

  // Bit positions that have a source wired; bank 0 in the low slice.
  localparam logic [NUM_SRC-1:0] SRC_PRESENT = {24'hFEFFFB, 24'hE9FFDF};

  typedef struct packed {
    logic [NUM_BANKS-1:0] clrStat;
    logic [NUM_BANKS-1:0] ldMask;
    logic [NUM_BANKS-1:0] rdStat;
    logic [NUM_BANKS-1:0] rdMask;
  } ctrlStrobes_t;

  function automatic logic [ADDR_W-1:0] statOffset(input int bank);
    return ADDR_W'(BANK_STRIDE * bank);
  endfunction

  function automatic logic [ADDR_W-1:0] maskOffset(input int bank);
    return ADDR_W'(BANK_STRIDE * bank + 1);
  endfunction
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobes.rdStat[b]  = (regAddr == statOffset(b));
      strobes.rdMask[b]  = (regAddr == maskOffset(b));
      strobes.clrStat[b] = regWrEn && (regAddr == statOffset(b));
      strobes.ldMask[b]  = regWrEn && (regAddr == maskOffset(b));
    end
  end
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  ctrlStrobes_t       strobes,
  input  logic [BANK_W-1:0]  wrBits,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] statFlat,
  output logic [NUM_SRC-1:0] maskFlat,
  output logic [NUM_SRC-1:0] riseFlat
);
  localparam int PAD_W = DATA_W - BANK_W;

  logic [NUM_SRC-1:0] prevEvt;
  logic [NUM_BANKS-1:0] bankPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEvt <= '0;
    else       prevEvt <= evtIn;
  end

  assign riseFlat = evtIn & ~prevEvt & SRC_PRESENT;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [BANK_W-1:0] statQ;
    logic [BANK_W-1:0] maskQ;
    logic [BANK_W-1:0] clrBits;
    logic [BANK_W-1:0] setBits;

    assign clrBits = strobes.clrStat[b] ? wrBits : '0;
    assign setBits = riseFlat[b*BANK_W +: BANK_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statQ <= '0;
        maskQ <= '1;
      end else begin
        statQ <= (statQ & ~clrBits) | setBits;
        if (strobes.ldMask[b]) maskQ <= wrBits;
      end
    end

    assign statFlat[b*BANK_W +: BANK_W] = statQ;
    assign maskFlat[b*BANK_W +: BANK_W] = maskQ;
    assign bankPending[b] = |(statQ & ~maskQ);
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.rdStat[b]) rdData = {{PAD_W{1'b0}}, statFlat[b*BANK_W +: BANK_W]};
      if (strobes.rdMask[b]) rdData = {{PAD_W{1'b0}}, maskFlat[b*BANK_W +: BANK_W]};
    end
  end

  assign irqOut = |bankPending;
endmodule

// File: rtl/irq_dual_bank.sv
module irq_dual_bank
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  ctrlStrobes_t strobes;
  logic [NUM_SRC-1:0] statFlat;
  logic [NUM_SRC-1:0] maskFlat;
  logic [NUM_SRC-1:0] riseFlat;
  logic unusedWrHi;

  assign unusedWrHi = ^regWrData[DATA_W-1:BANK_W];

  irq_reg_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irq_bank_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .strobes  (strobes),
    .wrBits   (regWrData[BANK_W-1:0]),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .statFlat (statFlat),
    .maskFlat (maskFlat),
    .riseFlat (riseFlat)
  );
endmodule

// File: rtl/irq_dual_bank_chk.sv
module irq_dual_bank_chk
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statFlat,
  input logic [NUM_SRC-1:0] maskFlat,
  input logic [NUM_SRC-1:0] riseFlat
);
  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (riseFlat != '0) |=> ((statFlat & $past(riseFlat)) == $past(riseFlat)));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == statOffset(0) || regAddr == statOffset(1)))
      |=> ((statFlat & $past(riseFlat)) == $past(riseFlat)));

  assert_no_source_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statFlat & ~SRC_PRESENT) == '0);

  assert_upper_byte_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:BANK_W] == '0);

  assert_all_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (&maskFlat) |-> !irqOut);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBankChk
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
      !(regWrEn && regAddr == statOffset(b))
        |=> ((statFlat[b*BANK_W +: BANK_W] & $past(statFlat[b*BANK_W +: BANK_W]))
             == $past(statFlat[b*BANK_W +: BANK_W])));
  end
endmodule

bind irq_dual_bank irq_dual_bank_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .statFlat  (statFlat),
  .maskFlat  (maskFlat),
  .riseFlat  (riseFlat)
);

// File: tb/irq_dual_bank_test.sv
`timescale 1ns/1ps
module irq_dual_bank_test;
  localparam int NSRC = 48;
  localparam logic [23:0] VALID0 = 24'hFFFFFF & ~(24'h1 << 5 | 24'h1 << 17 | 24'h1 << 18 | 24'h1 << 20);
  localparam logic [23:0] VALID1 = 24'hFFFFFF & ~(24'h1 << 2 | 24'h1 << 16);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] evtIn = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [23:0] statM [2];
  logic [23:0] maskM [2];
  logic [NSRC-1:0] prevM;

  always #4 clk = ~clk;

  irq_dual_bank uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {8'h0, statM[0]};
      3'd1: return {8'h0, maskM[0]};
      3'd3: return {8'h0, statM[1]};
      3'd4: return {8'h0, maskM[1]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expIrq();
    return |(statM[0] & ~maskM[0]) || |(statM[1] & ~maskM[1]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    statM[0] = '0; statM[1] = '0;
    maskM[0] = 24'hFFFFFF; maskM[1] = 24'hFFFFFF;
    prevM = '0;
  endtask

  // Drive one cycle, check read data and irq before the edge, then update the model.
  task automatic step(input logic [NSRC-1:0] e, input logic we,
                      input logic [2:0] a, input logic [31:0] d, input string req);
    logic [NSRC-1:0] rise;
    @(negedge clk);
    check({req, " irq R8"}, {31'h0, irqOut}, {31'h0, expIrq()});
    evtIn = e; regWrEn = we; regAddr = a; regWrData = d;
    #1;
    check({req, " read R1"}, regRdData, expRead(a));
    @(posedge clk);
    rise = e & ~prevM;
    for (int b = 0; b < 2; b++) begin
      logic [23:0] clr;
      clr = (we && a == 3'(3 * b)) ? d[23:0] : 24'h0;
      statM[b] = (statM[b] & ~clr) | (rise[b*24 +: 24] & (b == 0 ? VALID0 : VALID1));
      if (we && a == 3'(3 * b + 1)) maskM[b] = d[23:0];
    end
    prevM = e;
  endtask

  task automatic readChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] e;
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11 / R7 reset state
    readChk(3'd0, 32'h0, "R11 status0 after reset");
    readChk(3'd3, 32'h0, "R11 status1 after reset");
    readChk(3'd1, 32'h00FFFFFF, "R7 mask0 after reset");
    readChk(3'd4, 32'h00FFFFFF, "R7 mask1 after reset");
    check("R11 irq after reset", {31'h0, irqOut}, 32'h0);

    // R2/R3: edge on wire 0 and wire 30
    e = '0; e[0] = 1'b1; e[30] = 1'b1;
    step(e, 1'b0, 3'd0, 0, "R2");
    readChk(3'd0, 32'h1, "R2 wire0 -> bank0 bit0");
    readChk(3'd3, 32'h40, "R2 wire30 -> bank1 bit6");
    check("R4 masked pending keeps irq low", {31'h0, irqOut}, 32'h0);

    // R7/R8: unmask bit 0
    step(e, 1'b1, 3'd1, 32'h00FFFFFE, "R7");
    readChk(3'd1, 32'h00FFFFFE, "R7 mask load");
    check("R8 unmasked pending raises irq", {31'h0, irqOut}, 32'h1);

    // R5: write zero leaves status, write one clears (wire 0 still high)
    step(e, 1'b1, 3'd0, 32'h0, "R5");
    readChk(3'd0, 32'h1, "R5 zero write keeps bit");
    step(e, 1'b1, 3'd0, 32'h1, "R5");
    readChk(3'd0, 32'h0, "R5 one write clears bit");
    check("R8 irq drops after clear", {31'h0, irqOut}, 32'h0);
    step(e, 1'b0, 3'd0, 0, "R3");
    readChk(3'd0, 32'h0, "R3 held level does not re-set");

    // R6: edge and clear in the same cycle
    e[0] = 1'b0;
    step(e, 1'b0, 3'd0, 0, "R6");
    e[0] = 1'b1;
    step(e, 1'b1, 3'd0, 32'h1, "R6");
    readChk(3'd0, 32'h1, "R6 set wins over clear");

    // R9: edges on absent bits, all unmasked
    step(e, 1'b1, 3'd1, 32'h0, "R9");
    step(e, 1'b1, 3'd4, 32'h0, "R9");
    step(e, 1'b1, 3'd0, 32'hFFFFFFFF, "R9");
    step(e, 1'b1, 3'd3, 32'hFFFFFFFF, "R9");
    e = '0;
    step(e, 1'b0, 3'd0, 0, "R9");
    e[5] = 1'b1; e[17] = 1'b1; e[18] = 1'b1; e[20] = 1'b1; e[26] = 1'b1; e[40] = 1'b1;
    step(e, 1'b0, 3'd0, 0, "R9");
    readChk(3'd0, 32'h0, "R9 bank0 absent bits");
    readChk(3'd3, 32'h0, "R9 bank1 absent bits");
    check("R9 irq stays low", {31'h0, irqOut}, 32'h0);

    // R10 / R1: upper byte and unused offsets
    step(e, 1'b1, 3'd1, 32'hFF000000, "R10");
    readChk(3'd1, 32'h0, "R10 upper byte ignored on mask write");
    step(e, 1'b1, 3'd2, 32'hFFFFFFFF, "R1");
    step(e, 1'b1, 3'd7, 32'hFFFFFFFF, "R1");
    readChk(3'd2, 32'h0, "R1 offset 2 reads zero");
    readChk(3'd4, 32'h0, "R1 mask1 untouched by unused offsets");

    // Restore full masking, then random traffic
    step(e, 1'b1, 3'd1, 32'h00FFFFFF, "R7");
    step(e, 1'b1, 3'd4, 32'h00FFFFFF, "R7");
    check("R7 all masked keeps irq low", {31'h0, irqOut}, {31'h0, expIrq()});
    for (int i = 0; i < 3000; i++) begin
      logic [NSRC-1:0] flip;
      logic we;
      flip = NSRC'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      e = e ^ flip;
      we = ($urandom % 4) == 0;
      step(e, we, 3'($urandom % 8), $urandom, "R2 R3 R4 R5 R6 random");
    end
    step(e, 1'b0, 3'd0, 0, "R8 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule